// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits in front of a byte-wide parallel flash array and turns host write cycles into operation requests. The host presents each byte address over an 11-bit multiplexed bus. The low half is taken when the row/column strobe falls, and the high half is taken when it rises. The data byte is taken when the active-low write enable returns high. All of these pins are sampled on the system clock, and their edges are found by comparing each sample with the one before it.

The decoder follows the unlock sequences written by the host. It accepts a four-write byte-program sequence and three six-write erase sequences (sector, block and chip). When a sequence completes, it raises a one-clock start pulse. The pulse carries an encoded operation kind, the target address (aligned for erases) and the final data byte. If a write arrives while the array reports itself busy, the decoder drops it. If a write arrives out of sequence, the decoder returns to idle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the decoder returns to idle, `op_start` is low and the operation outputs clear to zero. A sequence that is partly entered before reset does not complete afterwards.
- R2: On a falling edge of `rc_strobe`, `mux_addr` supplies address bits 10..0. On a rising edge, it supplies bits 21..11. The byte address of a write is the 22-bit value formed from the most recent captures of each half.
- R3: When the clock edge samples `we_n` high after it was low, `wr_data` is taken. `op_start` goes high for exactly one clock, starting right after that edge, only when the write completes a sequence.
- R4: Byte-program is the write sequence A0h to key address A, after AAh to key address A and then 55h to key address B. The write that follows gives `op_kind` 0, and its full address and data appear on `op_addr` and `op_data`.
- R5: Sector-erase is AAh@A, 55h@B, 80h@A, AAh@A, 55h@B, then 30h. It gives `op_kind` 1, with `op_addr` equal to the sixth write's address with bits 11..0 cleared.
- R6: Block-erase is the same five writes followed by 50h. It gives `op_kind` 2, with bits 15..0 of the sixth address cleared.
- R7: Chip-erase is the same five writes followed by 10h at key address A. It gives `op_kind` 3 and `op_addr` zero. A 10h sent to any other address starts nothing.
- R8: Key address A is 5555h and key address B is 2AAAh. Only address bits 14..0 are compared against them, so the upper bits are ignored.
- R9: A write whose address or data does not match the expected step returns the decoder to idle without a start. A correct full sequence entered afterwards works normally.
- R10: A write whose rising `we_n` edge is seen while `busy` is high is ignored. It does not advance the sequence and does not reset it.
- R11: `op_data` carries the data byte of the completing write (the program byte, or the erase code). `op_kind`, `op_addr` and `op_data` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rc_strobe | input | 1 | Row/column strobe: falling edge takes the low address half, rising edge the high half |
| we_n | input | 1 | Active-low write enable; the rising edge completes a write |
| mux_addr | input | 11 | Multiplexed address half |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | High while the array runs an internal operation |
| op_start | output | 1 | One-clock start pulse |
| op_kind | output | 2 | 0 program, 1 sector-erase, 2 block-erase, 3 chip-erase |
| op_addr | output | 22 | Target address (aligned for erases, zero for chip-erase) |
| op_data | output | 8 | Data byte of the completing write |

## Verification
An address half is due in the capture register one clock after the edge that sees the strobe change. The start pulse and its fields are due one clock after the edge that sees `we_n` high. The bench drives every input on the falling clock edge, so each rising edge sees stable values.

A behavioural model in the bench computes the expected outputs on each rising edge. The bench compares them with the design at the next falling edge, which is the point where those one-clock latencies have elapsed.

For each scenario, the bench also counts the start pulses it observes, waits two further falling edges, and then checks the count and the captured fields against values worked out from the requirements.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int ADDR_W    = 22;
    localparam int ROW_W     = 11;
    localparam int COL_W     = ADDR_W - ROW_W;
    localparam int BUS_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int DATA_W    = 8;
    localparam int KEY_CMP_W = 15;

    localparam logic [KEY_CMP_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] CODE_UNLOCK_A = 8'hAA;
    localparam logic [DATA_W-1:0] CODE_UNLOCK_B = 8'h55;
    localparam logic [DATA_W-1:0] CODE_PROGRAM  = 8'hA0;
    localparam logic [DATA_W-1:0] CODE_ERASE    = 8'h80;
    localparam logic [DATA_W-1:0] CODE_SECTOR   = 8'h30;
    localparam logic [DATA_W-1:0] CODE_BLOCK    = 8'h50;
    localparam logic [DATA_W-1:0] CODE_CHIP     = 8'h10;

    typedef enum logic [1:0] {
        OP_PROGRAM      = 2'd0,
        OP_SECTOR_ERASE = 2'd1,
        OP_BLOCK_ERASE  = 2'd2,
        OP_CHIP_ERASE   = 2'd3
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_cycle_t;

    typedef struct packed {
        op_kind_t          kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } op_req_t;

    // True when a write hits the given key address with the given code.
    function automatic logic key_hit(input bus_cycle_t cyc,
                                     input logic [KEY_CMP_W-1:0] key_addr,
                                     input logic [DATA_W-1:0] code);
        return (cyc.addr[KEY_CMP_W-1:0] == key_addr) && (cyc.data == code);
    endfunction

    // Clears the low 'lsb' bits of an address.
    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                     input int lsb);
        logic [ADDR_W-1:0] r;
        for (int i = 0; i < ADDR_W; i++) begin
            r[i] = (i < lsb) ? 1'b0 : a[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/fcd_edge_det.sv
module fcd_edge_det #(
    parameter int          N       = 2,
    parameter logic [N-1:0] IDLE_LV = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= IDLE_LV[g];
            else        prev_q[g] <= sig[g];
        end
        assign rise[g] = rst_n & ~prev_q[g] &  sig[g];
        assign fall[g] = rst_n &  prev_q[g] & ~sig[g];
    end

endmodule

// File: rtl/fcd_addr_capture.sv
module fcd_addr_capture
    import fcd_pkg::*;
#(
    parameter int ROW_BITS = ROW_W,
    parameter int COL_BITS = COL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         row_take,
    input  logic                         col_take,
    input  logic [BUS_W-1:0]             bus,
    output logic [ROW_BITS+COL_BITS-1:0] addr
);

    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (row_take) row_q <= bus[ROW_BITS-1:0];
            if (col_take) col_q <= bus[COL_BITS-1:0];
        end
    end

    assign addr = {col_q, row_q};

    // R2
    row_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_take |=> addr[ROW_BITS-1:0] == $past(bus[ROW_BITS-1:0]));

    // R2
    col_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_take |=> addr[ROW_BITS+COL_BITS-1:ROW_BITS] == $past(bus[COL_BITS-1:0]));

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
#(
    parameter int SECTOR_LSB = 12,
    parameter int BLOCK_LSB  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       busy,
    input  bus_cycle_t cyc,
    output logic       start,
    output op_req_t    req
);

    seq_state_t state_q, state_d;
    logic       fire;
    op_kind_t   kind_d;
    logic       accept;

    assign accept = wr_stb & ~busy;

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        kind_d  = OP_PROGRAM;
        if (accept) begin
            unique case (state_q)
                ST_IDLE:
                    state_d = key_hit(cyc, KEY_ADDR_A, CODE_UNLOCK_A) ? ST_UNLK1 : ST_IDLE;
                ST_UNLK1:
                    state_d = key_hit(cyc, KEY_ADDR_B, CODE_UNLOCK_B) ? ST_UNLK2 : ST_IDLE;
                ST_UNLK2: begin
                    if (key_hit(cyc, KEY_ADDR_A, CODE_PROGRAM))    state_d = ST_PGM_ARM;
                    else if (key_hit(cyc, KEY_ADDR_A, CODE_ERASE)) state_d = ST_ERS_ARM;
                    else                                           state_d = ST_IDLE;
                end
                ST_PGM_ARM: begin
                    state_d = ST_IDLE;
                    fire    = 1'b1;
                    kind_d  = OP_PROGRAM;
                end
                ST_ERS_ARM:
                    state_d = key_hit(cyc, KEY_ADDR_A, CODE_UNLOCK_A) ? ST_ERS_UNLK1 : ST_IDLE;
                ST_ERS_UNLK1:
                    state_d = key_hit(cyc, KEY_ADDR_B, CODE_UNLOCK_B) ? ST_ERS_UNLK2 : ST_IDLE;
                ST_ERS_UNLK2: begin
                    state_d = ST_IDLE;
                    if (cyc.data == CODE_SECTOR) begin
                        fire   = 1'b1;
                        kind_d = OP_SECTOR_ERASE;
                    end else if (cyc.data == CODE_BLOCK) begin
                        fire   = 1'b1;
                        kind_d = OP_BLOCK_ERASE;
                    end else if (key_hit(cyc, KEY_ADDR_A, CODE_CHIP)) begin
                        fire   = 1'b1;
                        kind_d = OP_CHIP_ERASE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    function automatic logic [ADDR_W-1:0] target(input op_kind_t k,
                                                 input logic [ADDR_W-1:0] a);
        unique case (k)
            OP_SECTOR_ERASE: return align_down(a, SECTOR_LSB);
            OP_BLOCK_ERASE:  return align_down(a, BLOCK_LSB);
            OP_CHIP_ERASE:   return '0;
            default:         return a;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start   <= 1'b0;
            req     <= '0;
        end else begin
            state_q <= state_d;
            start   <= fire;
            if (fire) begin
                req.kind <= kind_d;
                req.addr <= target(kind_d, cyc.addr);
                req.data <= cyc.data;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q == ST_IDLE) && !start);

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy) |=> (state_q == $past(state_q)) && !start);

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(wr_stb) && !$past(busy));

    // R5
    sector_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req.kind == OP_SECTOR_ERASE) |-> req.addr[SECTOR_LSB-1:0] == '0);

    // R6
    block_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req.kind == OP_BLOCK_ERASE) |-> req.addr[BLOCK_LSB-1:0] == '0);

    // R7
    chip_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req.kind == OP_CHIP_ERASE) |-> req.addr == '0);

    // R11
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && $past(rst_n)) |-> $stable(req));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int SECTOR_LSB = 12,
    parameter int BLOCK_LSB  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rc_strobe,
    input  logic               we_n,
    input  logic [BUS_W-1:0]   mux_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               busy,
    output logic               op_start,
    output logic [1:0]         op_kind,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [DATA_W-1:0]  op_data
);

    localparam int STB_RC = 0;
    localparam int STB_WE = 1;

    logic [1:0]        stb_rise, stb_fall;
    logic [ADDR_W-1:0] cur_addr;
    bus_cycle_t        cyc;
    op_req_t           req;

    fcd_edge_det #(.N(2), .IDLE_LV(2'b11)) i_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({we_n, rc_strobe}),
        .rise  (stb_rise),
        .fall  (stb_fall)
    );

    fcd_addr_capture #(.ROW_BITS(ROW_W), .COL_BITS(COL_W)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_take (stb_fall[STB_RC]),
        .col_take (stb_rise[STB_RC]),
        .bus      (mux_addr),
        .addr     (cur_addr)
    );

    assign cyc.addr = cur_addr;
    assign cyc.data = wr_data;

    fcd_seq_fsm #(.SECTOR_LSB(SECTOR_LSB), .BLOCK_LSB(BLOCK_LSB)) i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (stb_rise[STB_WE]),
        .busy   (busy),
        .cyc    (cyc),
        .start  (op_start),
        .req    (req)
    );

    assign op_kind = req.kind;
    assign op_addr = req.addr;
    assign op_data = req.data;

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rc_strobe = 1'b1;
    logic        we_n = 1'b1;
    logic [10:0] mux_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [21:0] op_addr;
    logic [7:0]  op_data;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int dut_starts = 0;
    logic [1:0]  seen_kind;
    logic [21:0] seen_addr;
    logic [7:0]  seen_data;
    bit compare_on = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_strobe (rc_strobe),
        .we_n      (we_n),
        .mux_addr  (mux_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_data   (op_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    int          m_step = 0;
    bit          m_prev_rc = 1, m_prev_we = 1;
    logic [10:0] m_row = '0, m_col = '0;
    bit          m_start = 0;
    int          m_kind = 0;
    logic [21:0] m_addr = '0;
    logic [7:0]  m_data = '0;

    task automatic m_fire(input int k, input logic [21:0] a, input logic [7:0] d);
        m_start = 1;
        m_kind  = k;
        m_data  = d;
        if (k == 1)      m_addr = a & 22'h3FF000;
        else if (k == 2) m_addr = a & 22'h3F0000;
        else if (k == 3) m_addr = 22'h0;
        else             m_addr = a;
    endtask

    always @(posedge clk) begin
        logic [21:0] a;
        logic [14:0] lo;
        if (!rst_n) begin
            m_step = 0; m_prev_rc = 1; m_prev_we = 1;
            m_row = '0; m_col = '0; m_start = 0;
            m_kind = 0; m_addr = '0; m_data = '0;
        end else begin
            m_start = 0;
            if (!m_prev_we && we_n && !busy) begin
                a  = {m_col, m_row};
                lo = a[14:0];
                if (m_step == 0)
                    m_step = (lo == 15'h5555 && wr_data == 8'hAA) ? 1 : 0;
                else if (m_step == 1 || m_step == 5)
                    m_step = (lo == 15'h2AAA && wr_data == 8'h55) ? m_step + 1 : 0;
                else if (m_step == 2)
                    m_step = (lo == 15'h5555 && wr_data == 8'hA0) ? 3 :
                             (lo == 15'h5555 && wr_data == 8'h80) ? 4 : 0;
                else if (m_step == 3) begin
                    m_fire(0, a, wr_data); m_step = 0;
                end else if (m_step == 4)
                    m_step = (lo == 15'h5555 && wr_data == 8'hAA) ? 5 : 0;
                else begin
                    if (wr_data == 8'h30) m_fire(1, a, wr_data);
                    else if (wr_data == 8'h50) m_fire(2, a, wr_data);
                    else if (wr_data == 8'h10 && lo == 15'h5555) m_fire(3, a, wr_data);
                    m_step = 0;
                end
            end
            if (m_prev_rc && !rc_strobe) m_row = mux_addr;
            if (!m_prev_rc && rc_strobe) m_col = mux_addr;
            m_prev_rc = rc_strobe;
            m_prev_we = we_n;
        end
    end

    // Per-clock comparison and start bookkeeping, away from the active edge.
    always @(negedge clk) begin
        if (compare_on && !done) begin
            chk(op_start == m_start, "R3 start pulse per clock", op_start, m_start);
            chk(op_kind == 2'(m_kind), "R11 op_kind per clock", op_kind, m_kind);
            chk(op_addr == m_addr, "R2 op_addr per clock", op_addr, m_addr);
            chk(op_data == m_data, "R11 op_data per clock", op_data, m_data);
        end
        if (op_start) begin
            dut_starts++;
            seen_kind = op_kind;
            seen_addr = op_addr;
            seen_data = op_data;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            summary();
            $finish;
        end
    end

    task automatic bus_write(input logic [21:0] a, input logic [7:0] d);
        @(negedge clk) begin mux_addr = a[10:0]; rc_strobe = 1'b1; end
        @(negedge clk) rc_strobe = 1'b0;
        @(negedge clk) begin mux_addr = a[21:11]; rc_strobe = 1'b1; end
        @(negedge clk) begin wr_data = d; we_n = 1'b0; end
        @(negedge clk) we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic unlock();
        bus_write(22'h005555, 8'hAA);
        bus_write(22'h002AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        bus_write(22'h005555, 8'h80);
        unlock();
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(op_start == 0, "R1 reset op_start", op_start, 0);
        chk(op_addr == 0 && op_kind == 0 && op_data == 0, "R1 reset fields",
            {op_kind, op_addr, op_data}, 0);
        rst_n = 1'b1;
        compare_on = 1;

        // R4 R2 R3 R11: byte program
        base = dut_starts;
        unlock();
        bus_write(22'h005555, 8'hA0);
        bus_write(22'h3ABCDE, 8'h5A);
        settle();
        chk(dut_starts == base + 1, "R3 one start pulse for program", dut_starts, base + 1);
        chk(seen_kind == 2'd0, "R4 program kind", seen_kind, 0);
        chk(seen_addr == 22'h3ABCDE, "R2 program address halves", seen_addr, 22'h3ABCDE);
        chk(seen_data == 8'h5A, "R11 program data", seen_data, 8'h5A);

        // R5: sector erase
        base = dut_starts;
        erase_prefix();
        bus_write(22'h123456, 8'h30);
        settle();
        chk(dut_starts == base + 1, "R5 sector start", dut_starts, base + 1);
        chk(seen_kind == 2'd1, "R5 sector kind", seen_kind, 1);
        chk(seen_addr == 22'h123000, "R5 sector aligned address", seen_addr, 22'h123000);
        chk(seen_data == 8'h30, "R11 erase code on op_data", seen_data, 8'h30);

        // R6: block erase
        base = dut_starts;
        erase_prefix();
        bus_write(22'h2FABCD, 8'h50);
        settle();
        chk(dut_starts == base + 1, "R6 block start", dut_starts, base + 1);
        chk(seen_kind == 2'd2, "R6 block kind", seen_kind, 2);
        chk(seen_addr == 22'h2F0000, "R6 block aligned address", seen_addr, 22'h2F0000);

        // R7: chip erase, then wrong address for chip code
        base = dut_starts;
        erase_prefix();
        bus_write(22'h005555, 8'h10);
        settle();
        chk(dut_starts == base + 1, "R7 chip start", dut_starts, base + 1);
        chk(seen_kind == 2'd3, "R7 chip kind", seen_kind, 3);
        chk(seen_addr == 22'h0, "R7 chip address zero", seen_addr, 0);
        base = dut_starts;
        erase_prefix();
        bus_write(22'h001234, 8'h10);
        settle();
        chk(dut_starts == base, "R7 chip code off key address", dut_starts, base);
        chk(op_kind == 2'd3 && op_addr == 22'h0, "R11 fields hold without start",
            {op_kind, op_addr}, 0);

        // R8: upper address bits ignored on key compare
        base = dut_starts;
        bus_write(22'h3F5555, 8'hAA);
        bus_write(22'h3EAAAA, 8'h55);
        bus_write(22'h1D5555, 8'hA0);
        bus_write(22'h000777, 8'hC3);
        settle();
        chk(dut_starts == base + 1, "R8 upper bits ignored", dut_starts, base + 1);
        chk(seen_addr == 22'h000777 && seen_data == 8'hC3, "R8 program target",
            {seen_addr, seen_data}, {22'h000777, 8'hC3});

        // R9: mismatches return to idle
        base = dut_starts;
        unlock();
        bus_write(22'h005555, 8'h90);
        bus_write(22'h000100, 8'h11);
        bus_write(22'h005555, 8'hAA);
        bus_write(22'h002AAB, 8'h55);
        bus_write(22'h005555, 8'hA0);
        bus_write(22'h000200, 8'h22);
        settle();
        chk(dut_starts == base, "R9 mismatch starts nothing", dut_starts, base);
        unlock();
        bus_write(22'h005555, 8'hA0);
        bus_write(22'h000300, 8'h33);
        settle();
        chk(dut_starts == base + 1, "R9 recovery after mismatch", dut_starts, base + 1);

        // R10: writes while busy are dropped and the sequence is kept
        base = dut_starts;
        unlock();
        @(negedge clk) busy = 1'b1;
        bus_write(22'h005555, 8'hA0);
        bus_write(22'h000400, 8'h44);
        settle();
        chk(dut_starts == base, "R10 no start while busy", dut_starts, base);
        @(negedge clk) busy = 1'b0;
        bus_write(22'h005555, 8'hA0);
        bus_write(22'h000500, 8'h55);
        settle();
        chk(dut_starts == base + 1, "R10 sequence kept across busy", dut_starts, base + 1);
        chk(seen_addr == 22'h000500, "R10 target after busy", seen_addr, 22'h000500);

        // R1: reset drops a partial sequence
        base = dut_starts;
        unlock();
        bus_write(22'h005555, 8'hA0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk(op_addr == 0 && op_data == 0, "R1 fields cleared by reset", {op_addr, op_data}, 0);
        bus_write(22'h000600, 8'h66);
        settle();
        chk(dut_starts == base, "R1 partial sequence lost", dut_starts, base);

        done = 1;
        summary();
        $finish;
    end

endmodule